// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block decides which of up to 32 DMA channels is served next. Each channel can raise a request in two ways. A peripheral can drive a request line, and that line can be masked per channel. Software can also pulse a request through a register write. The request is then held as pending until the channel is served. Each channel carries four configuration bits: a request mask, an enable, a primary/alternate descriptor select and a priority level. Two more bits per channel enable its interrupts. Every one of these bit groups is changed only through a pair of set and clear registers, so software can touch one channel without a read-modify-write.

When the global master enable is on, the block picks one eligible channel. A channel at the high priority level beats any channel at the low level, and within a level the lowest channel number wins. The block announces the choice with a one-cycle grant pulse that carries the channel index and the RAM address of that channel's 16-byte control descriptor. The address is computed from a programmable base pointer, whose alignment follows from the channel count. After a grant the block waits for a done input before it arbitrates again. It then records end-of-transfer, and error if reported, in write-1-to-clear flag registers that drive two interrupt outputs.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset all configuration bits, pending software requests, flags and the base pointer read as zero, the master enable is off, and grantValid, irqDone and irqErr are low.
- R2: Register codes on wrAddr/rdAddr: 0 control (bit 0 master enable), 1 base pointer, 2/3 mask set/clear, 4/5 enable set/clear, 6/7 alternate set/clear, 8/9 priority set/clear, 10/11 end-of-transfer interrupt enable set/clear, 12/13 error interrupt enable set/clear, 14 software request, 15 end-of-transfer flags, 16 error flags. Bit n of a data word refers to channel n. For each set/clear pair, writing 1 to bit n sets or clears channel n's bit, a 0 leaves it unchanged, and both codes of the pair read back the current group value.
- R3: An eligible channel whose priority bit is 1 wins over every eligible channel whose priority bit is 0.
- R4: Among eligible channels at the same priority level, the lowest channel number wins.
- R5: Writing 1 to bit n of the software request register makes channel n pending. The request stays pending, and reads back at code 14, until the channel is granted. The request mask does not apply to it.
- R6: No grant is issued while the master enable is 0. A software request made meanwhile stays pending, and it is granted one cycle after the enable write.
- R7: A peripheral request on a channel whose mask bit is 1 is ignored.
- R8: A channel whose enable bit is 0 never wins, and its pending software request is dropped. It does not come back when the channel is enabled again.
- R9: A grant raises grantValid for exactly one cycle together with grantCh and descAddr. No further grant occurs until doneIn is seen. A grant is due one cycle after the request becomes visible at a clock edge.
- R10: descAddr is base + 16*n for the primary descriptor. For the alternate descriptor (alternate bit set) it is base + A + 16*n, with A = 16 * 2^ceil(log2(NUM_CH)), which is 0x80 for 8 channels.
- R11: Base pointer bits below log2(2*A) are ignored on write and read as zero.
- R12: doneIn after a grant sets that channel's end-of-transfer flag. errIn together with doneIn also sets its error flag. Writing 1 clears a flag and writing 0 leaves it. irqDone and irqErr are the OR of the flags ANDed with their enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | Register code for the write |
| wrData | input | 32 | Write data |
| rdAddr | input | 5 | Register code for the combinational read |
| rdData | output | 32 | Read data |
| periphReq | input | NUM_CH | Peripheral request lines, one per channel |
| doneIn | input | 1 | Current transfer finished |
| errIn | input | 1 | Current transfer ended with an error (sampled with doneIn) |
| grantValid | output | 1 | One-cycle grant pulse |
| grantCh | output | CH_BITS | Granted channel index |
| descAddr | output | 32 | Descriptor address of the granted channel |
| irqDone | output | 1 | End-of-transfer interrupt |
| irqErr | output | 1 | Error interrupt |

## Verification
A register write lands at the clock edge that closes its write cycle, and the readback is combinational, so every readback is sampled at the next falling edge. A software request, a peripheral request or a master-enable write that is visible at edge k gives a grant that is registered at edge k+1. The bench therefore checks grantValid, grantCh and descAddr exactly one falling edge after the write task returns, or after the request line is driven. It then checks at the following falling edge that the pulse has ended. Flags and interrupt outputs follow doneIn or a flag write by one edge, and they are sampled at the falling edge that comes right after it.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int DATA_W = 32;
  localparam int NGRP = 6;
  localparam int G_MASK = 0;
  localparam int G_EN = 1;
  localparam int G_ALT = 2;
  localparam int G_PRI = 3;
  localparam int G_DIE = 4;
  localparam int G_EIE = 5;
  localparam logic [4:0] A_CTRL = 5'd0;
  localparam logic [4:0] A_BASE = 5'd1;
  localparam logic [4:0] A_SW = 5'd14;
  localparam logic [4:0] A_DFLAG = 5'd15;
  localparam logic [4:0] A_EFLAG = 5'd16;

  typedef struct packed {
    logic       grant;
    logic       done;
    logic       err;
    logic [4:0] ch;
  } ctrlStrb_t;
endpackage

// File: rtl/dma_arb_ctrl.sv
module dma_arb_ctrl
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_BITS = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               masterEn,
  input  logic [NUM_CH-1:0]  elig,
  input  logic [NUM_CH-1:0]  pri,
  input  logic               doneIn,
  input  logic               errIn,
  output ctrlStrb_t          strb,
  output logic               grantValid,
  output logic [CH_BITS-1:0] grantCh
);
  typedef enum logic {ST_IDLE, ST_BUSY} state_t;
  state_t state;
  logic [CH_BITS-1:0] curCh, hiIdx, loIdx, winCh;
  logic hiAny, loAny;

  always_comb begin
    hiAny = 1'b0; loAny = 1'b0;
    hiIdx = '0;   loIdx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (elig[i] && pri[i]) begin hiAny = 1'b1; hiIdx = CH_BITS'(i); end
      if (elig[i] && !pri[i]) begin loAny = 1'b1; loIdx = CH_BITS'(i); end
    end
    winCh = hiAny ? hiIdx : loIdx;
  end

  always_comb begin
    strb.grant = (state == ST_IDLE) && masterEn && (hiAny || loAny);
    strb.done  = (state == ST_BUSY) && doneIn;
    strb.err   = (state == ST_BUSY) && doneIn && errIn;
    strb.ch    = 5'(strb.grant ? winCh : curCh);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      curCh <= '0;
      grantValid <= 1'b0;
      grantCh <= '0;
    end else begin
      grantValid <= strb.grant;
      if (strb.grant) begin
        state <= ST_BUSY;
        curCh <= winCh;
        grantCh <= winCh;
      end else if (strb.done) begin
        state <= ST_IDLE;
      end
    end
  end

  AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |=> !grantValid); // R9
  AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> $past(masterEn)); // R6
  AST_HIGH_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (strb.grant && |(elig & pri)) |-> pri[winCh]); // R3
endmodule

// File: rtl/dma_arb_dpath.sv
module dma_arb_dpath
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_BITS = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [4:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [4:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [NUM_CH-1:0] periphReq,
  input  ctrlStrb_t         strb,
  output logic              masterEn,
  output logic [NUM_CH-1:0] elig,
  output logic [NUM_CH-1:0] pri,
  output logic [DATA_W-1:0] descAddr,
  output logic              irqDone,
  output logic              irqErr
);
  localparam int ALT_SHIFT = 4 + $clog2(NUM_CH);
  localparam int ALIGN_BITS = ALT_SHIFT + 1;
  localparam logic [DATA_W-1:0] ALT_OFS = DATA_W'(1) << ALT_SHIFT;
  localparam logic [DATA_W-1:0] BASE_MASK = ~((DATA_W'(1) << ALIGN_BITS) - DATA_W'(1));

  logic [NUM_CH-1:0] cfg [NGRP];
  logic [NUM_CH-1:0] swPend, doneFlag, errFlag, wrBits, chOneHot;
  logic [DATA_W-1:0] baseReg;
  logic [CH_BITS-1:0] chIdx;

  assign wrBits = wrData[NUM_CH-1:0];
  assign chIdx = strb.ch[CH_BITS-1:0];
  assign chOneHot = NUM_CH'(1) << chIdx;

  for (genvar g = 0; g < NGRP; g++) begin : g_cfg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cfg[g] <= '0;
      else if (wrEn && wrAddr == 5'(2 + 2 * g)) cfg[g] <= cfg[g] | wrBits;
      else if (wrEn && wrAddr == 5'(3 + 2 * g)) cfg[g] <= cfg[g] & ~wrBits;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      masterEn <= 1'b0;
      baseReg <= '0;
      swPend <= '0;
      doneFlag <= '0;
      errFlag <= '0;
      descAddr <= '0;
    end else begin
      if (wrEn && wrAddr == A_CTRL) masterEn <= wrData[0];
      if (wrEn && wrAddr == A_BASE) baseReg <= wrData & BASE_MASK;
      swPend <= (swPend | ((wrEn && wrAddr == A_SW) ? wrBits : '0))
                & cfg[G_EN] & ~(strb.grant ? chOneHot : '0);
      doneFlag <= (doneFlag & ~((wrEn && wrAddr == A_DFLAG) ? wrBits : '0))
                  | (strb.done ? chOneHot : '0);
      errFlag <= (errFlag & ~((wrEn && wrAddr == A_EFLAG) ? wrBits : '0))
                 | (strb.err ? chOneHot : '0);
      if (strb.grant)
        descAddr <= baseReg + (cfg[G_ALT][chIdx] ? ALT_OFS : '0)
                    + (DATA_W'(chIdx) << 4);
    end
  end

  assign elig = ((periphReq & ~cfg[G_MASK]) | swPend) & cfg[G_EN];
  assign pri = cfg[G_PRI];
  assign irqDone = |(doneFlag & cfg[G_DIE]);
  assign irqErr = |(errFlag & cfg[G_EIE]);

  always_comb begin
    rdData = '0;
    for (int g = 0; g < NGRP; g++)
      if (rdAddr == 5'(2 + 2 * g) || rdAddr == 5'(3 + 2 * g))
        rdData = DATA_W'(cfg[g]);
    case (rdAddr)
      A_CTRL:  rdData = DATA_W'(masterEn);
      A_BASE:  rdData = baseReg;
      A_SW:    rdData = DATA_W'(swPend);
      A_DFLAG: rdData = DATA_W'(doneFlag);
      A_EFLAG: rdData = DATA_W'(errFlag);
      default: ;
    endcase
  end

  AST_GRANT_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    strb.grant |-> cfg[G_EN][chIdx]); // R8
  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |=> doneFlag[$past(chIdx)]); // R12
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_BITS = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [4:0]         wrAddr,
  input  logic [31:0]        wrData,
  input  logic [4:0]         rdAddr,
  output logic [31:0]        rdData,
  input  logic [NUM_CH-1:0]  periphReq,
  input  logic               doneIn,
  input  logic               errIn,
  output logic               grantValid,
  output logic [CH_BITS-1:0] grantCh,
  output logic [31:0]        descAddr,
  output logic               irqDone,
  output logic               irqErr
);
  ctrlStrb_t strb;
  logic masterEn;
  logic [NUM_CH-1:0] elig, pri;

  dma_arb_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rstN(rstN), .masterEn(masterEn), .elig(elig), .pri(pri),
    .doneIn(doneIn), .errIn(errIn), .strb(strb),
    .grantValid(grantValid), .grantCh(grantCh)
  );

  dma_arb_dpath #(.NUM_CH(NUM_CH)) u_dpath (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .periphReq(periphReq), .strb(strb),
    .masterEn(masterEn), .elig(elig), .pri(pri), .descAddr(descAddr),
    .irqDone(irqDone), .irqErr(irqErr)
  );

  AST_DESC_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> (descAddr[3:0] == 4'd0)); // R10
endmodule

// File: tb/dma_req_arbiter_tb.sv
module dma_req_arbiter_tb;
  localparam int NUM_CH = 8;
  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, doneIn = 1'b0, errIn = 1'b0;
  logic [4:0] wrAddr = '0, rdAddr = '0;
  logic [31:0] wrData = '0, rdData, descAddr;
  logic [NUM_CH-1:0] periphReq = '0;
  logic grantValid, irqDone, irqErr;
  logic [2:0] grantCh;
  int nChk = 0, nErr = 0;
  localparam logic [31:0] BASE = 32'h2000_0100;

  always #2 clk = ~clk;

  dma_req_arbiter #(.NUM_CH(NUM_CH)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .periphReq(periphReq), .doneIn(doneIn),
    .errIn(errIn), .grantValid(grantValid), .grantCh(grantCh),
    .descAddr(descAddr), .irqDone(irqDone), .irqErr(irqErr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(logic [4:0] a, logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rdChk(string req, logic [4:0] a, logic [31:0] exp);
    rdAddr = a; #1; chk(req, rdData, exp);
  endtask

  task automatic expGrant(string req, int ch, logic [31:0] addr);
    chk(req, {31'd0, grantValid}, 32'd1);
    chk(req, {29'd0, grantCh}, 32'(ch));
    chk(req, descAddr, addr);
    @(negedge clk);
    chk({req, " pulse"}, {31'd0, grantValid}, 32'd0);
  endtask

  task automatic noGrant(string req, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, {31'd0, grantValid}, 32'd0);
    end
  endtask

  task automatic pulseDone(logic e);
    @(negedge clk); doneIn = 1'b1; errIn = e;
    @(negedge clk); doneIn = 1'b0; errIn = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 grant", {31'd0, grantValid}, 32'd0);
    chk("R1 irq", {30'd0, irqDone, irqErr}, 32'd0);
    rdChk("R1 enable", 5'd4, 32'd0);
    rdChk("R1 base", 5'd1, 32'd0);
    rdChk("R1 ctrl", 5'd0, 32'd0);
  endtask

  task automatic t_cfg();
    wrReg(5'd4, 32'h0F); rdChk("R2 set", 5'd4, 32'h0F);
    wrReg(5'd4, 32'h30); rdChk("R2 set keeps", 5'd5, 32'h3F);
    wrReg(5'd5, 32'h05); rdChk("R2 clear", 5'd4, 32'h3A);
    wrReg(5'd4, 32'hFF); rdChk("R2 all", 5'd4, 32'hFF);
    wrReg(5'd1, 32'h2000_01FF); rdChk("R11 base low", 5'd1, BASE);
    wrReg(5'd0, 32'h1);
  endtask

  task automatic t_prio();
    wrReg(5'd8, 32'h20); wrReg(5'd6, 32'h04);
    @(negedge clk); periphReq = 8'h24;
    @(negedge clk); expGrant("R3 high wins", 5, BASE + 32'h50);
    noGrant("R9 wait done", 4);
    periphReq = 8'h04;
    pulseDone(1'b0);
    @(negedge clk); expGrant("R10 alternate", 2, BASE + 32'h80 + 32'h20);
    periphReq = 8'h00;
    pulseDone(1'b0);
    rdChk("R12 done flags", 5'd15, 32'h24);
  endtask

  task automatic t_tie();
    wrReg(5'd9, 32'h20); wrReg(5'd7, 32'h04);
    @(negedge clk); periphReq = 8'h48;
    @(negedge clk); expGrant("R4 lowest", 3, BASE + 32'h30);
    periphReq = 8'h40;
    pulseDone(1'b0);
    @(negedge clk); expGrant("R4 next", 6, BASE + 32'h60);
    periphReq = 8'h00;
    pulseDone(1'b0);
  endtask

  task automatic t_mask();
    wrReg(5'd2, 32'h02);
    periphReq = 8'h02;
    noGrant("R7 masked", 4);
    wrReg(5'd14, 32'h02);
    @(negedge clk); expGrant("R5 sw unmasked", 1, BASE + 32'h10);
    periphReq = 8'h00;
    pulseDone(1'b0);
    wrReg(5'd3, 32'h02);
  endtask

  task automatic t_master();
    wrReg(5'd0, 32'h0);
    wrReg(5'd14, 32'h80);
    noGrant("R6 master off", 4);
    rdChk("R5 pending held", 5'd14, 32'h80);
    wrReg(5'd0, 32'h1);
    @(negedge clk); expGrant("R6 master on", 7, BASE + 32'h70);
    rdChk("R5 pending cleared", 5'd14, 32'h00);
    pulseDone(1'b0);
  endtask

  task automatic t_disable();
    wrReg(5'd5, 32'h10);
    wrReg(5'd14, 32'h10);
    noGrant("R8 disabled", 3);
    rdChk("R8 dropped", 5'd14, 32'h00);
    wrReg(5'd4, 32'h10);
    noGrant("R8 no revive", 3);
  endtask

  task automatic t_flags();
    rdChk("R12 flags", 5'd15, 32'hEE);
    chk("R12 irq off", {31'd0, irqDone}, 32'd0);
    wrReg(5'd10, 32'h08); #1;
    chk("R12 irq on", {31'd0, irqDone}, 32'd1);
    wrReg(5'd15, 32'h08); rdChk("R12 w1c", 5'd15, 32'hE6);
    chk("R12 irq cleared", {31'd0, irqDone}, 32'd0);
    wrReg(5'd14, 32'h01);
    @(negedge clk); expGrant("R9 ch0", 0, BASE);
    pulseDone(1'b1);
    rdChk("R12 err flag", 5'd16, 32'h01);
    chk("R12 err irq off", {31'd0, irqErr}, 32'd0);
    wrReg(5'd12, 32'h01); #1;
    chk("R12 err irq on", {31'd0, irqErr}, 32'd1);
    wrReg(5'd16, 32'h01); rdChk("R12 err w1c", 5'd16, 32'h00);
    chk("R12 err irq cleared", {31'd0, irqErr}, 32'd0);
    wrReg(5'd15, 32'h00); rdChk("R12 zero write", 5'd15, 32'hE7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk); rstN = 1'b1;
    t_reset();
    t_cfg();
    t_prio();
    t_tie();
    t_mask();
    t_master();
    t_disable();
    t_flags();
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    #400000;
    nErr++; nChk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule